// File: doc/BRIEF.md
# Blocked Carry Lookahead Adder

A purely combinational adder that adds two WIDTH-bit operands and a carry-in and gives a WIDTH-bit sum and a carry-out. Each operand bit yields a generate term (a AND b) and a propagate term (a OR b). The word is split into 4-bit slices. Within a slice, every internal carry is one flat sum of products over the lower generate and propagate terms and the slice's incoming carry. No carry is built from the carry one bit below it. Each sum bit is the XOR of the two operand bits and the carry into that bit.

Each slice also exports a group generate and a group propagate. A parameter picks how carries cross slice boundaries. In one setting they pass slice to slice, using group generate OR (group propagate AND incoming carry). In the other setting a second lookahead level expands the carry into every slice, in the same flat form, over the group signals of all lower slices. The block is meant for datapaths that want a shorter carry path than a plain ripple chain without the irregular wiring of a full-width lookahead.

Top module: `cla_adder`

## Requirements
- R1: For every input, {cout, sum} equals a + b + cin evaluated at WIDTH+1 bits.
- R2: grp_gen[k] is 1 exactly when a[4k+3:4k] + b[4k+3:4k] exceeds 15 with no carry in, i.e. slice k generates a carry on its own.
- R3: grp_prop[k] is 1 exactly when every bit position of slice k has a or b set, i.e. (a | b) over bits 4k+3..4k is all ones.
- R4: With a all ones, b zero and cin = 1, the carry travels the whole word: sum is zero and cout is 1.
- R5: With a and b all ones and cin = 1, sum is all ones and cout is 1.
- R6: cin has no effect on grp_gen or grp_prop; flipping cin alone leaves both unchanged.
- R7: The slice-to-slice setting (LEVEL2 = 0) and the second-level lookahead setting (LEVEL2 = 1) give identical sum, cout, grp_gen and grp_prop for the same inputs.
- R8: With all inputs zero, sum, cout, grp_gen and grp_prop are all zero.
- R9: sum[0] equals a[0] XOR b[0] XOR cin, so the carry-in enters at the least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant bit |
| grp_gen | output | WIDTH/4 | Group generate, one bit per 4-bit slice |
| grp_prop | output | WIDTH/4 | Group propagate, one bit per 4-bit slice |

## Verification
All-zero inputs give a baseline. All ones plus cin = 1 drives a carry through every slice boundary. Doubled all-ones separates carries that are generated from carries that are only propagated. Alternating bit patterns and slice-local sums of exactly 15 and 16 test where each slice's group generate and group propagate switch. Random vectors exercise mixed carry patterns. Each vector goes to both carry-crossing variants, and a cin toggle with fixed operands shows that the group outputs do not depend on the carry-in.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // Bits per lookahead slice; the slice carry logic is written for this size.
   localparam int SLICE_W = 4;

   function automatic int slice_count(input int width);
      return width / SLICE_W;
   endfunction
endpackage

// File: rtl/cla_pg_bits.sv
// Per-bit generate, inclusive-OR propagate and half-sum terms.
module cla_pg_bits #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] g,
   output logic [W-1:0] p,
   output logic [W-1:0] h
);
   assign g = a & b;
   assign p = a | b;
   assign h = a ^ b;
endmodule

// File: rtl/cla_sop.sv
// Flat two-level carry expansion: c[i] = g[i-1] + p[i-1]g[i-2] + ... + p[i-1..0]c0.
// N carries come out (c[0] is c0); N-1 generate/propagate pairs go in.
module cla_sop #(
   parameter int N = 4
) (
   input  logic [N-2:0] g,
   input  logic [N-2:0] p,
   input  logic         c0,
   output logic [N-1:0] c
);
   always_comb begin
      logic acc;
      logic term;
      c[0] = c0;
      for (int i = 1; i < N; i++) begin
         acc = 1'b0;
         for (int j = 0; j < i; j++) begin
            term = g[j];
            for (int k = j + 1; k < i; k++) term = term & p[k];
            acc = acc | term;
         end
         term = c0;
         for (int k = 0; k < i; k++) term = term & p[k];
         c[i] = acc | term;
      end
   end
endmodule

// File: rtl/cla_group_pg.sv
// Group generate and propagate of one slice, formed from bit terms only.
module cla_group_pg #(
   parameter int SW = cla_pkg::SLICE_W
) (
   input  logic [SW-1:0] g,
   input  logic [SW-1:0] p,
   output logic          gg,
   output logic          gp
);
   always_comb begin
      logic term;
      gg = 1'b0;
      for (int j = 0; j < SW; j++) begin
         term = g[j];
         for (int k = j + 1; k < SW; k++) term = term & p[k];
         gg = gg | term;
      end
      gp = &p;
   end
endmodule

// File: rtl/cla_sum_slice.sv
// One slice: internal carries by flat lookahead, then sum bits.
module cla_sum_slice #(
   parameter int SW = cla_pkg::SLICE_W
) (
   input  logic [SW-2:0] g,
   input  logic [SW-2:0] p,
   input  logic [SW-1:0] h,
   input  logic          cin,
   output logic [SW-1:0] s
);
   logic [SW-1:0] c;

   cla_sop #(.N(SW)) u_sop (
      .g  (g),
      .p  (p),
      .c0 (cin),
      .c  (c)
   );

   assign s = h ^ c;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
   parameter int WIDTH  = 32,
   parameter bit LEVEL2 = 1'b1
) (
   input  logic [WIDTH-1:0]                    a,
   input  logic [WIDTH-1:0]                    b,
   input  logic                                cin,
   output logic [WIDTH-1:0]                    sum,
   output logic                                cout,
   output logic [WIDTH/cla_pkg::SLICE_W-1:0]   grp_gen,
   output logic [WIDTH/cla_pkg::SLICE_W-1:0]   grp_prop
);
   localparam int SW   = cla_pkg::SLICE_W;
   localparam int NBLK = cla_pkg::slice_count(WIDTH);

   if (WIDTH < SW || (WIDTH % SW) != 0) begin : g_bad_width
      $error("cla_adder: WIDTH must be a positive multiple of the slice width");
   end

   logic [WIDTH-1:0] g_bit, p_bit, h_bit;
   logic [NBLK:0]    blk_c;

   cla_pg_bits #(.W(WIDTH)) u_pg (
      .a (a),
      .b (b),
      .g (g_bit),
      .p (p_bit),
      .h (h_bit)
   );

   for (genvar k = 0; k < NBLK; k++) begin : g_slice
      cla_group_pg #(.SW(SW)) u_grp (
         .g  (g_bit[k*SW +: SW]),
         .p  (p_bit[k*SW +: SW]),
         .gg (grp_gen[k]),
         .gp (grp_prop[k])
      );
      cla_sum_slice #(.SW(SW)) u_sum (
         .g   (g_bit[k*SW +: SW-1]),
         .p   (p_bit[k*SW +: SW-1]),
         .h   (h_bit[k*SW +: SW]),
         .cin (blk_c[k]),
         .s   (sum[k*SW +: SW])
      );
   end

   if (LEVEL2 && NBLK > 1) begin : g_lookahead
      logic [NBLK-1:0] c_in;
      cla_sop #(.N(NBLK)) u_top_sop (
         .g  (grp_gen[NBLK-2:0]),
         .p  (grp_prop[NBLK-2:0]),
         .c0 (cin),
         .c  (c_in)
      );
      assign blk_c[NBLK-1:0] = c_in;
      assign blk_c[NBLK] = grp_gen[NBLK-1] | (grp_prop[NBLK-1] & c_in[NBLK-1]);
   end else begin : g_chain
      always_comb begin
         blk_c[0] = cin;
         for (int k = 0; k < NBLK; k++)
            blk_c[k+1] = grp_gen[k] | (grp_prop[k] & blk_c[k]);
      end
   end

   assign cout = blk_c[NBLK];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0]                  a,
   input logic [WIDTH-1:0]                  b,
   input logic                              cin,
   input logic [WIDTH-1:0]                  sum,
   input logic                              cout,
   input logic [WIDTH/cla_pkg::SLICE_W-1:0] grp_gen,
   input logic [WIDTH/cla_pkg::SLICE_W-1:0] grp_prop
);
   localparam int SW   = cla_pkg::SLICE_W;
   localparam int NBLK = cla_pkg::slice_count(WIDTH);

   always_comb begin
      logic [WIDTH:0] ref_total;
      logic [SW:0]    ref_slice;
      ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      assert_total_R1: assert ({cout, sum} == ref_total)
         else $error("total mismatch");
      assert_lsb_R9: assert (sum[0] == (a[0] ^ b[0] ^ cin))
         else $error("lsb mismatch");
      for (int k = 0; k < NBLK; k++) begin
         ref_slice = {1'b0, a[k*SW +: SW]} + {1'b0, b[k*SW +: SW]};
         assert_grp_gen_R2: assert (grp_gen[k] == ref_slice[SW])
            else $error("group generate mismatch");
         assert_grp_prop_R3: assert (grp_prop[k] == ((a[k*SW +: SW] | b[k*SW +: SW]) == {SW{1'b1}}))
            else $error("group propagate mismatch");
      end
   end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .a        (a),
   .b        (b),
   .cin      (cin),
   .sum      (sum),
   .cout     (cout),
   .grp_gen  (grp_gen),
   .grp_prop (grp_prop)
);

// File: tb/cla_adder_test.sv
`timescale 1ns/1ps
module cla_adder_test;
   localparam int W  = 32;
   localparam int NB = W / 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0]  a, b;
   logic          cin;
   logic [W-1:0]  sum, sum_r;
   logic          cout, cout_r;
   logic [NB-1:0] gg, gp, gg_r, gp_r;

   int n_cmp = 0;
   int n_bad = 0;

   cla_adder #(.WIDTH(W), .LEVEL2(1'b1)) uut (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_gen(gg), .grp_prop(gp));
   cla_adder #(.WIDTH(W), .LEVEL2(1'b0)) uut_rip (
      .a(a), .b(b), .cin(cin), .sum(sum_r), .cout(cout_r), .grp_gen(gg_r), .grp_prop(gp_r));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
      end
   endtask

   task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
      @(posedge clk);
      #1;
      a = av; b = bv; cin = cv;
      @(negedge clk);
   endtask

   function automatic logic [NB-1:0] exp_gen(input logic [W-1:0] av, input logic [W-1:0] bv);
      logic [NB-1:0] r;
      for (int k = 0; k < NB; k++) r[k] = ((av >> (4*k)) & 4'hF) + ((bv >> (4*k)) & 4'hF) > 15;
      return r;
   endfunction

   function automatic logic [NB-1:0] exp_prop(input logic [W-1:0] av, input logic [W-1:0] bv);
      logic [NB-1:0] r;
      for (int k = 0; k < NB; k++) r[k] = (((av | bv) >> (4*k)) & 4'hF) == 4'hF;
      return r;
   endfunction

   // Full check of one vector against arithmetic and against the other variant.
   task automatic check_vec(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
      logic [W:0] ref_t;
      apply(av, bv, cv);
      ref_t = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
      chk("R1 sum+cout", {31'b0, cout, sum}, {31'b0, ref_t});
      chk("R2 grp_gen", {56'b0, gg}, {56'b0, exp_gen(av, bv)});
      chk("R3 grp_prop", {56'b0, gp}, {56'b0, exp_prop(av, bv)});
      chk("R9 lsb", {63'b0, sum[0]}, {63'b0, av[0] ^ bv[0] ^ cv});
      chk("R7 variants", {15'b0, cout_r, gg_r, gp_r, sum_r}, {15'b0, cout, gg, gp, sum});
   endtask

   task automatic t_zero();
      apply('0, '0, 1'b0);
      chk("R8 zero", {15'b0, cout, gg, gp, sum}, 64'd0);
   endtask

   task automatic t_full_ripple();
      apply('1, '0, 1'b1);
      chk("R4 sum", {32'b0, sum}, 64'd0);
      chk("R4 cout", {63'b0, cout}, 64'd1);
      check_vec('1, '0, 1'b1);
   endtask

   task automatic t_all_ones();
      apply('1, '1, 1'b1);
      chk("R5 sum", {32'b0, sum}, {32'b0, {W{1'b1}}});
      chk("R5 cout", {63'b0, cout}, 64'd1);
      check_vec('1, '1, 1'b0);
   endtask

   task automatic t_patterns();
      check_vec(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
      check_vec(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
      check_vec(32'h8888_8888, 32'h8888_8888, 1'b0);
      check_vec(32'h7777_7777, 32'h9999_9999, 1'b0);   // slices sum to 16
      check_vec(32'h7777_7777, 32'h8888_8888, 1'b1);   // slices sum to 15
      check_vec(32'h0000_000F, 32'h0000_0001, 1'b0);
      check_vec(32'h8000_0000, 32'h8000_0000, 1'b0);
      check_vec(32'h0F0F_0F0F, 32'h00F0_F0F0, 1'b1);
   endtask

   task automatic t_cin_indep();
      logic [NB-1:0] g0, p0;
      for (int i = 0; i < 20; i++) begin
         logic [W-1:0] av, bv;
         av = $urandom; bv = $urandom;
         apply(av, bv, 1'b0);
         g0 = gg; p0 = gp;
         apply(av, bv, 1'b1);
         chk("R6 grp_gen vs cin", {56'b0, gg}, {56'b0, g0});
         chk("R6 grp_prop vs cin", {56'b0, gp}, {56'b0, p0});
      end
   endtask

   task automatic t_random();
      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] av, bv;
         av = $urandom; bv = $urandom;
         if (i % 3 == 0) bv = ~av;
         check_vec(av, bv, 1'($urandom));
      end
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      repeat (2) @(posedge clk);
      t_zero();
      t_full_ripple();
      t_all_ones();
      t_patterns();
      t_cin_indep();
      t_random();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule